// File: doc/BRIEF.md
# Keyed-Restart Watchdog Counter

This block is a memory-mapped watchdog for a simple register bus with 32-bit address and data and single-cycle read and write strobes. A down-counter is preset from a reload register and steps once per tick. The tick is either every bus clock or a slow enable input. Software keeps the watchdog alive by writing a fixed 16-bit key to a restart register. Any other value written there does nothing, so a stray write cannot hold off the timeout.

When the counter steps while it reads zero, the block records a timeout and presets itself again. The enabled expiry actions then follow. It can raise a level interrupt, issue a one-cycle reset request together with a scope code, and issue a one-cycle start strobe for an external reset pulse. It can also latch a boot-from-secondary state, which swaps the two flash chip-select lines until software clears it. Reset enters asynchronously and is released through a two-stage synchronizer.

Top module: `magic_wdog_top`

## Requirements
- R1: After reset the counter (offset 0x00), reload (0x04), control (0x0C) and status (0x10) all read 0. The interrupt, reset request and pulse start outputs are 0, and the chip-select outputs equal the inputs.
- R2: The reload register at 0x04 reads back the value written. The control register at 0x0C reads back its 8 bits with zeros above. Offsets 0x08, 0x14 and unmapped addresses read 0, and reads return data combinationally while the read strobe is high.
- R3: A write to control that takes bit 0 (run) from 0 to 1 presets the counter from the reload register at that clock edge.
- R4: While run is set, the counter decreases by one per tick. With control bit 4 at 0 every bus clock is a tick; with bit 4 at 1 only cycles with the slow tick input high are ticks.
- R5: A write to 0x08 whose low 16 bits equal 0x4755 presets the counter from the reload register. This works whether the counter is running or stopped. Any other value written to 0x08 has no effect.
- R6: Expiry occurs on a tick that finds the counter at 0 with no preset in the same cycle. At expiry the counter is preset from reload and keeps running, and status bit 0 is set.
- R7: The interrupt output is high while status bit 0 is set and control bit 2 is set.
- R8: If control bit 1 is set, an expiry produces a one-cycle reset request in the cycle after the expiry edge. The scope output always shows control bits 6:5: 00 SoC, 01 full chip, 10 CPU only.
- R9: If control bit 3 is set, an expiry produces a one-cycle external pulse start in the cycle after the expiry edge.
- R10: If control bit 7 is set, an expiry sets status bit 1, and while it stays set the chip-select outputs are swapped (out[0]=in[1], out[1]=in[0]).
- R11: Writing 0x14 with bit 0 at 1 clears both status bits and restores the direct chip-select mapping. With bit 0 at 0 the write has no effect, and clearing an already clear status leaves everything unchanged. An expiry in the same cycle takes priority.
- R12: While run is clear and no preset occurs, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_slow_i | input | 1 | Slow tick enable, used when control bit 4 is set |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 32 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid while the read strobe is high |
| cs_in_i | input | 2 | Flash chip selects from the flash controller |
| cs_out_o | output | 2 | Chip selects to the flash devices, swapped in secondary boot state |
| irq_o | output | 1 | Timeout interrupt level |
| rst_req_o | output | 1 | One-cycle reset request |
| rst_scope_o | output | 2 | Scope of the requested reset |
| ext_start_o | output | 1 | One-cycle start strobe for the external reset pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit counter and 32-bit bus. It writes reload values below 24, so the counter reaches zero many times in a short run, including a reload of 0, which expires on every tick. Random control values switch between the bus-clock and slow-tick sources, set every combination of expiry actions and scope codes, and toggle run. Restart writes, wrong-key writes and clears then land close to expiries, including in the same cycle.

// File: rtl/magic_wdog_pkg.sv
package magic_wdog_pkg;

  localparam logic [7:0] OFS_COUNT  = 8'h00;
  localparam logic [7:0] OFS_RELOAD = 8'h04;
  localparam logic [7:0] OFS_KICK   = 8'h08;
  localparam logic [7:0] OFS_CTRL   = 8'h0C;
  localparam logic [7:0] OFS_STAT   = 8'h10;
  localparam logic [7:0] OFS_CLR    = 8'h14;

  localparam logic [15:0] KICK_KEY = 16'h4755;

  // control register layout, bit 7 down to bit 0
  typedef struct packed {
    logic       alt_boot;
    logic [1:0] scope;
    logic       use_slow;
    logic       ext_en;
    logic       irq_en;
    logic       rst_en;
    logic       run;
  } wdog_ctrl_t;

endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
  import magic_wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [1:0]        stat_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  reload_o,
  output wdog_ctrl_t        ctrl_o,
  output logic              load_o,
  output logic              clr_o
);

  localparam int unsigned CTRL_W = $bits(wdog_ctrl_t);

  logic hit_reload, hit_ctrl, hit_kick, hit_clr, hit_cnt, hit_stat;
  logic reload_we, ctrl_we;
  logic [CNT_W-1:0] reload_q, reload_d;
  wdog_ctrl_t ctrl_q, ctrl_d;
  logic run_rise, kick_ok;

  assign hit_cnt    = (addr_i == ADDR_W'(OFS_COUNT));
  assign hit_reload = (addr_i == ADDR_W'(OFS_RELOAD));
  assign hit_kick   = (addr_i == ADDR_W'(OFS_KICK));
  assign hit_ctrl   = (addr_i == ADDR_W'(OFS_CTRL));
  assign hit_stat   = (addr_i == ADDR_W'(OFS_STAT));
  assign hit_clr    = (addr_i == ADDR_W'(OFS_CLR));

  always_comb begin
    reload_we = wr_i & hit_reload;
    ctrl_we   = wr_i & hit_ctrl;
    reload_d  = wdata_i[CNT_W-1:0];
    ctrl_d    = wdog_ctrl_t'(wdata_i[CTRL_W-1:0]);
    run_rise  = ctrl_we & ctrl_d.run & ~ctrl_q.run;
    kick_ok   = wr_i & hit_kick & (wdata_i[15:0] == KICK_KEY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
    end else if (reload_we) begin
      reload_q <= reload_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (hit_cnt)    rdata_o = DATA_W'(cnt_i);
      if (hit_reload) rdata_o = DATA_W'(reload_q);
      if (hit_ctrl)   rdata_o = DATA_W'(ctrl_q);
      if (hit_stat)   rdata_o = DATA_W'(stat_i);
    end
  end

  assign reload_o = reload_q;
  assign ctrl_o   = ctrl_q;
  assign load_o   = run_rise | kick_ok;
  assign clr_o    = wr_i & hit_clr & wdata_i[0];

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             use_slow_i,
  input  logic             tick_slow_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic tick, step, at_zero, cnt_we, expire;

  always_comb begin
    tick    = use_slow_i ? tick_slow_i : 1'b1;
    step    = run_i & tick;
    at_zero = (cnt_q == '0);
    expire  = step & at_zero & ~load_i;
    cnt_we  = load_i | step;
    cnt_d   = cnt_q;
    if (load_i) begin
      cnt_d = reload_i;
    end else if (step) begin
      cnt_d = at_zero ? reload_i : (cnt_q - CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign expire_o = expire;

  // R4
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tick && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R6
  expire_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == $past(reload_i)));

  // R12
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !load_i) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog_actions.sv
module wdog_actions (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire_i,
  input  logic       clr_i,
  input  logic       alt_boot_i,
  input  logic       rst_en_i,
  input  logic       irq_en_i,
  input  logic       ext_en_i,
  input  logic [1:0] scope_i,
  input  logic [1:0] cs_in_i,
  output logic [1:0] stat_o,
  output logic [1:0] cs_out_o,
  output logic       irq_o,
  output logic       rst_req_o,
  output logic [1:0] rst_scope_o,
  output logic       ext_start_o
);

  localparam int unsigned NUM_CS = 2;

  logic [1:0] stat_q, stat_d;
  logic stat_we;
  logic rst_req_q, rst_req_d, ext_q, ext_d;

  always_comb begin
    stat_d = stat_q;
    if (clr_i) stat_d = 2'b00;
    if (expire_i) begin
      stat_d[0] = 1'b1;
      if (alt_boot_i) stat_d[1] = 1'b1;
    end
    stat_we   = expire_i | clr_i;
    rst_req_d = expire_i & rst_en_i;
    ext_d     = expire_i & ext_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_we) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req_q <= 1'b0;
      ext_q     <= 1'b0;
    end else begin
      rst_req_q <= rst_req_d;
      ext_q     <= ext_d;
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_out_o[g] = stat_q[1] ? cs_in_i[NUM_CS-1-g] : cs_in_i[g];
  end

  assign stat_o      = stat_q;
  assign irq_o       = stat_q[0] & irq_en_i;
  assign rst_req_o   = rst_req_q;
  assign ext_start_o = ext_q;
  assign rst_scope_o = scope_i;

  // R10
  alt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[1] && !clr_i) |=> stat_q[1]);

  // R11
  clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !expire_i) |=> (stat_q == 2'b00));

endmodule

// File: rtl/magic_wdog_top.sv
module magic_wdog_top
  import magic_wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_slow_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [1:0]        cs_in_i,
  output logic [1:0]        cs_out_o,
  output logic              irq_o,
  output logic              rst_req_o,
  output logic [1:0]        rst_scope_o,
  output logic              ext_start_o
);

  logic [1:0] rst_sync_q;
  logic rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sn = rst_sync_q[1];

  logic [CNT_W-1:0] cnt, reload;
  logic [1:0] stat;
  wdog_ctrl_t ctrl;
  logic load, clr, expire;

  wdog_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sn),
    .wr_i     (bus_wr_i),
    .rd_i     (bus_rd_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .cnt_i    (cnt),
    .stat_i   (stat),
    .rdata_o  (bus_rdata_o),
    .reload_o (reload),
    .ctrl_o   (ctrl),
    .load_o   (load),
    .clr_o    (clr)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_sn),
    .run_i       (ctrl.run),
    .use_slow_i  (ctrl.use_slow),
    .tick_slow_i (tick_slow_i),
    .load_i      (load),
    .reload_i    (reload),
    .cnt_o       (cnt),
    .expire_o    (expire)
  );

  wdog_actions u_act (
    .clk         (clk),
    .rst_n       (rst_sn),
    .expire_i    (expire),
    .clr_i       (clr),
    .alt_boot_i  (ctrl.alt_boot),
    .rst_en_i    (ctrl.rst_en),
    .irq_en_i    (ctrl.irq_en),
    .ext_en_i    (ctrl.ext_en),
    .scope_i     (ctrl.scope),
    .cs_in_i     (cs_in_i),
    .stat_o      (stat),
    .cs_out_o    (cs_out_o),
    .irq_o       (irq_o),
    .rst_req_o   (rst_req_o),
    .rst_scope_o (rst_scope_o),
    .ext_start_o (ext_start_o)
  );

endmodule

// File: tb/magic_wdog_tb.sv
module magic_wdog_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        tick_slow;
  logic        wr, rd;
  logic [31:0] addr, wdata, rdata;
  logic [1:0]  cs_in, cs_out, scope;
  logic        irq, rst_req, ext_start;

  magic_wdog_top u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_slow_i (tick_slow),
    .bus_wr_i    (wr),
    .bus_rd_i    (rd),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .cs_in_i     (cs_in),
    .cs_out_o    (cs_out),
    .irq_o       (irq),
    .rst_req_o   (rst_req),
    .rst_scope_o (scope),
    .ext_start_o (ext_start)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference state
  logic [31:0] m_cnt, m_rel;
  logic [7:0]  m_ctrl;
  logic        m_st0, m_st1, m_rq, m_ext;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [31:0] a);
    case (a)
      32'h00:  return m_cnt;
      32'h04:  return m_rel;
      32'h0C:  return {24'h0, m_ctrl};
      32'h10:  return {30'h0, m_st1, m_st0};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_req(input logic [31:0] a);
    case (a)
      32'h00:  return "R4";
      32'h10:  return "R6";
      default: return "R2";
    endcase
  endfunction

  // drive inputs at the falling edge and compare against the reference
  task automatic drive(input logic w, input logic r, input logic [31:0] a, input logic [31:0] d,
                       input logic t, input logic [1:0] c);
    wr = w; rd = r; addr = a; wdata = d; tick_slow = t; cs_in = c;
    #1;
    chk("R7", "irq", {31'h0, irq}, {31'h0, m_st0 & m_ctrl[2]});
    chk("R8", "rst_req", {31'h0, rst_req}, {31'h0, m_rq});
    chk("R8", "scope", {30'h0, scope}, {30'h0, m_ctrl[6:5]});
    chk("R9", "ext_start", {31'h0, ext_start}, {31'h0, m_ext});
    chk("R10", "cs_out", {30'h0, cs_out}, {30'h0, m_st1 ? {c[0], c[1]} : c});
    if (r) chk(rd_req(a), "rdata", rdata, exp_rd(a));
  endtask

  task automatic advance();
    logic tk, step, load, exp_now, clr;
    logic [31:0] n_cnt, n_rel;
    logic [7:0]  n_ctrl;
    logic n_st0, n_st1;
    tk      = m_ctrl[4] ? tick_slow : 1'b1;
    step    = m_ctrl[0] & tk;
    load    = (wr && addr == 32'h0C && wdata[0] && !m_ctrl[0]) ||
              (wr && addr == 32'h08 && wdata[15:0] == 16'h4755);
    exp_now = step && !load && m_cnt == 32'h0;
    clr     = wr && addr == 32'h14 && wdata[0];
    n_cnt   = load ? m_rel : step ? ((m_cnt == 0) ? m_rel : m_cnt - 1) : m_cnt;
    n_rel   = (wr && addr == 32'h04) ? wdata : m_rel;
    n_ctrl  = (wr && addr == 32'h0C) ? wdata[7:0] : m_ctrl;
    n_st0   = exp_now ? 1'b1 : clr ? 1'b0 : m_st0;
    n_st1   = (exp_now && m_ctrl[7]) ? 1'b1 : clr ? 1'b0 : m_st1;
    @(posedge clk);
    m_rq  = exp_now & m_ctrl[1];
    m_ext = exp_now & m_ctrl[3];
    m_cnt = n_cnt; m_rel = n_rel; m_ctrl = n_ctrl; m_st0 = n_st0; m_st1 = n_st1;
    @(negedge clk);
  endtask

  task automatic cyc(input logic w, input logic r, input logic [31:0] a, input logic [31:0] d,
                     input logic t, input logic [1:0] c);
    drive(w, r, a, d, t, c);
    advance();
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_cnt = 0; m_rel = 0; m_ctrl = 0; m_st0 = 0; m_st1 = 0; m_rq = 0; m_ext = 0;
    rst_n = 1'b0;
    wr = 0; rd = 0; addr = 0; wdata = 0; tick_slow = 0; cs_in = 2'b01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) cyc(0, 0, 0, 0, 0, 2'b01);

    // R1 reset state
    drive(0, 1, 32'h00, 0, 0, 2'b01); chk("R1", "count", rdata, 0); advance();
    drive(0, 1, 32'h04, 0, 0, 2'b01); chk("R1", "reload", rdata, 0); advance();
    drive(0, 1, 32'h0C, 0, 0, 2'b01); chk("R1", "ctrl", rdata, 0); advance();
    drive(0, 1, 32'h10, 0, 0, 2'b01); chk("R1", "status", rdata, 0);
    chk("R1", "cs_out", {30'h0, cs_out}, 32'h1); advance();

    // R2 reload readback
    cyc(1, 0, 32'h04, 32'd3, 0, 2'b01);
    drive(0, 1, 32'h04, 0, 0, 2'b01); chk("R2", "reload", rdata, 3); advance();
    // R3 run rise presets: alt, scope 01, ext, irq, rst, run
    cyc(1, 0, 32'h0C, 32'hAF, 0, 2'b01);
    drive(0, 1, 32'h0C, 0, 0, 2'b01); chk("R2", "ctrl", rdata, 32'hAF); advance();
    // counter was preset to 3 and has since stepped once
    drive(0, 1, 32'h00, 0, 0, 2'b01); chk("R4", "count", rdata, 2); advance();
    // R5 wrong key ignored
    cyc(1, 0, 32'h08, 32'h1234, 0, 2'b01);
    drive(0, 1, 32'h00, 0, 0, 2'b01); chk("R5", "count after bad key", rdata, 0); advance();
    // R6 expiry presets and sets status
    drive(0, 1, 32'h00, 0, 0, 2'b01);
    chk("R6", "count after expiry", rdata, 3);
    chk("R8", "rst_req", {31'h0, rst_req}, 1);
    chk("R8", "scope", {30'h0, scope}, 1);
    chk("R9", "ext_start", {31'h0, ext_start}, 1);
    chk("R7", "irq", {31'h0, irq}, 1);
    chk("R10", "cs swapped", {30'h0, cs_out}, 32'h2);
    advance();
    drive(0, 1, 32'h10, 0, 0, 2'b01);
    chk("R10", "status", rdata, 3);
    chk("R8", "rst_req one cycle", {31'h0, rst_req}, 0);
    advance();
    cyc(1, 0, 32'h0C, 32'h00, 0, 2'b01);
    cyc(1, 0, 32'h08, 32'h4755, 0, 2'b01);
    drive(0, 1, 32'h00, 0, 0, 2'b01); chk("R5", "count after key", rdata, 3); advance();
    drive(0, 1, 32'h00, 0, 0, 2'b01); chk("R12", "count held", rdata, 3); advance();
    cyc(1, 0, 32'h14, 32'h0, 0, 2'b01);
    drive(0, 1, 32'h10, 0, 0, 2'b01); chk("R11", "clear bit0=0", rdata, 3); advance();
    cyc(1, 0, 32'h14, 32'h1, 0, 2'b01);
    drive(0, 1, 32'h10, 0, 0, 2'b01); chk("R11", "cleared", rdata, 0);
    chk("R11", "cs restored", {30'h0, cs_out}, 32'h1); advance();
    cyc(1, 0, 32'h14, 32'h1, 0, 2'b01);
    drive(0, 1, 32'h10, 0, 0, 2'b01); chk("R11", "clear again", rdata, 0);
    chk("R11", "cs still normal", {30'h0, cs_out}, 32'h1); advance();
    // R4 slow tick source
    cyc(1, 0, 32'h0C, 32'h11, 0, 2'b01);
    drive(0, 1, 32'h00, 0, 0, 2'b01); chk("R4", "no slow tick", rdata, 3); advance();
    drive(0, 1, 32'h00, 0, 1, 2'b01); chk("R4", "before slow tick", rdata, 3); advance();
    drive(0, 1, 32'h00, 0, 0, 2'b01); chk("R4", "after slow tick", rdata, 2); advance();

    // constrained random phase
    for (int i = 0; i < 20000; i++) begin
      int unsigned op;
      logic t;
      logic [1:0] c;
      logic [31:0] d;
      op = $urandom % 16;
      t  = ($urandom % 4) == 0;
      c  = 2'($urandom);
      case (op)
        0, 1: cyc(1, 0, 32'h04, $urandom % 24, t, c);
        2, 3: begin
          d = {24'h0, 8'($urandom)};
          d[0] = ($urandom % 4) != 0;
          cyc(1, 0, 32'h0C, d, t, c);
        end
        4: cyc(1, 0, 32'h08, {16'($urandom), 16'h4755}, t, c);
        5: begin
          d = $urandom;
          if (d[15:0] == 16'h4755) d[0] = ~d[0];
          cyc(1, 0, 32'h08, d, t, c);
        end
        6: cyc(1, 0, 32'h14, $urandom, t, c);
        7, 8, 9, 10, 11, 12: begin
          int unsigned k;
          k = $urandom % 7;
          cyc(0, 1, (k == 6) ? 32'h18 : 32'(k * 4) + ((k >= 3) ? 32'h4 : 32'h0), 0, t, c);
        end
        default: cyc(0, 0, 0, 0, t, c);
      endcase
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule